// File: doc/BRIEF.md
# Audio Port Staged Enable Controller

This block brings up the transmit and receive sections of a multichannel audio serial port. Each direction owns five stages: a high-frequency clock divider, a bit clock divider, a serializer clear release, a state machine and a frame sync generator. A host turns them on one at a time over a plain register write/read bus. For every stage the readable control bit reports whether that stage is actually running, not whether it was requested. Software can therefore request a stage, poll its bit until it reads 1, and only then request the next.

Each direction also has a one-word data buffer that the serial shifter drains (transmit) or fills (receive) on slot pulses. Each serializer has a mode field and two readiness flags. Each direction has a sticky error flag that the host clears by writing a 1 to it. A write of zero to a direction's control bits shuts every stage of that direction down together. Stage activation passes through a two-register chain, which stands in for the crossing into the serial clock domain.

Top module: `aud_stage_ctrl`

## Requirements
- R1: After reset every stage reads 0, both error flags read 0, every serializer register reads 0 and both buffers are empty.
- R2: Suppose a write requests a stage whose predecessor is already running, and the write is taken at rising edge k. A read between edges k and k+1 shows that stage's bit as 0. From edge k+1 on it shows 1.
- R3: Stages come up in the fixed order high-frequency divider, bit clock divider, serializer clear, state machine, frame sync. A stage runs only while its requested bit is set and every earlier stage in that order runs. Once settled, the read-back equals the longest in-order prefix of the requested set. Receive bits: 0 bit clock, 1 high-frequency, 2 serializer clear, 3 state machine, 4 frame sync. Transmit uses the same bits at 8 to 12.
- R4: A write that leaves all five bits of a direction at zero stops every stage of that direction at the edge that takes the write.
- R5: Word address 0 writes both directions. Address 1 (receive alias) writes only bits 4:0. Address 2 (transmit alias) writes only bits 12:8. Each alias reads back only its own direction's bits.
- R6: While serializer clear is not running in a direction, that direction's buffer is held empty. Host writes to the transmit buffer (address 5) and receive slot captures are dropped.
- R7: Serializer n sits at word address 8+n. Its mode field is bits 1:0, where 1 is transmit and 2 is receive. Bit 4 (transmit-ready) reads 1 when the mode is transmit, the transmit state machine runs and the transmit buffer is empty.
- R8: Bit 5 (receive-ready) reads 1 when the mode is receive and the receive buffer holds an unread word. A read of address 6 with the read strobe returns that word and empties the buffer.
- R9: A transmit slot pulse while the transmit state machine and frame sync both run and the buffer is empty sets bit 0 of the transmit status (address 3). A slot with a full buffer empties it. The buffered word is presented on `tx_sample`.
- R10: A receive slot pulse while receive state machine and frame sync run captures `rx_sample` into an empty buffer. If the buffer is full, the pulse instead keeps the old word and sets bit 0 of the receive status (address 4).
- R11: A status bit clears only when a 1 is written to it. Writing 0 leaves it set. A new error in the same cycle as the clear wins.
- R12: A stage whose predecessor never comes up reads 0 indefinitely, and every read returns data in the same cycle, so a poll can never stall the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Read strobe (consumes the receive buffer at address 6) |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| tx_slot | input | 1 | Transmit shifter slot pulse |
| tx_sample | output | DATA_W | Word held in the transmit buffer |
| rx_slot | input | 1 | Receive shifter slot pulse |
| rx_sample | input | DATA_W | Word offered by the receive shifter |

## Verification
The properties assume that slot pulses and bus accesses are single-cycle strobes. They also assume that a receive buffer read never coincides with a receive slot. The bench keeps to both by driving every strobe for exactly one clock from the falling edge and by separating buffer reads from slot pulses. The ordering properties take for granted that only the defined addresses are written during a sequence. The stimulus uses no other addresses.

// File: rtl/aud_stage_pkg.sv
package aud_stage_pkg;
    localparam int NSTAGE   = 5;
    localparam int BIT_CLK  = 0;
    localparam int BIT_HF   = 1;
    localparam int BIT_SCLR = 2;
    localparam int BIT_SM   = 3;
    localparam int BIT_FS   = 4;
    localparam int RX_LSB   = 0;
    localparam int TX_LSB   = 8;

    localparam logic [4:0] ADR_BOTH   = 5'd0;
    localparam logic [4:0] ADR_RXCTL  = 5'd1;
    localparam logic [4:0] ADR_TXCTL  = 5'd2;
    localparam logic [4:0] ADR_TXSTAT = 5'd3;
    localparam logic [4:0] ADR_RXSTAT = 5'd4;
    localparam logic [4:0] ADR_TXBUF  = 5'd5;
    localparam logic [4:0] ADR_RXBUF  = 5'd6;
    localparam logic [4:0] ADR_SER0   = 5'd8;

    localparam logic [1:0] MODE_TX = 2'd1;
    localparam logic [1:0] MODE_RX = 2'd2;

    // bring-up position -> control bit
    function automatic int order_bit(input int pos);
        case (pos)
            0:       return BIT_HF;
            1:       return BIT_CLK;
            default: return pos;
        endcase
    endfunction

    typedef struct packed {
        logic [NSTAGE-1:0] req;
        logic [NSTAGE-1:0] sync;
        logic [NSTAGE-1:0] act;
    } chain_s;
endpackage

// File: rtl/aud_stage_chain.sv
module aud_stage_chain
    import aud_stage_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [NSTAGE-1:0] wbits,
    output logic [NSTAGE-1:0] act
);
    chain_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr) s_d.req = wbits;
        for (int p = 0; p < NSTAGE; p++) begin
            logic pred;
            logic en;
            pred = (p == 0) ? 1'b1 : s_q.act[order_bit(p - 1)];
            en   = s_d.req[order_bit(p)] & pred;
            s_d.sync[order_bit(p)] = en;
            s_d.act[order_bit(p)]  = en & s_q.sync[order_bit(p)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act = s_q.act;
endmodule

// File: rtl/aud_stage_buffer.sv
module aud_stage_buffer #(
    parameter int DATA_W = 32,
    parameter bit IS_TX  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              run,
    input  logic              slot,
    input  logic              host_acc,
    input  logic [DATA_W-1:0] host_data,
    input  logic [DATA_W-1:0] line_data,
    output logic              full,
    output logic [DATA_W-1:0] word,
    output logic              err
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] word;
    } buf_s;

    buf_s b_d, b_q;

    generate
        if (IS_TX) begin : g_tx
            always_comb begin
                b_d = b_q;
                err = 1'b0;
                if (run && slot) begin
                    if (b_q.full) b_d.full = 1'b0;
                    else          err      = 1'b1;
                end
                if (host_acc && !hold) begin
                    b_d.full = 1'b1;
                    b_d.word = host_data;
                end
                if (hold) b_d.full = 1'b0;
            end
            logic unused_line;
            assign unused_line = ^line_data;
        end else begin : g_rx
            always_comb begin
                b_d = b_q;
                err = 1'b0;
                if (host_acc) b_d.full = 1'b0;
                if (run && slot && !hold) begin
                    if (b_q.full && !host_acc) begin
                        err = 1'b1;
                    end else begin
                        b_d.full = 1'b1;
                        b_d.word = line_data;
                    end
                end
                if (hold) b_d.full = 1'b0;
            end
            logic unused_host;
            assign unused_host = ^host_data;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign full = b_q.full;
    assign word = b_q.word;
endmodule

// File: rtl/aud_stage_ctrl.sv
module aud_stage_ctrl
    import aud_stage_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32,
    parameter int NUM_SER = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_slot,
    output logic [DATA_W-1:0] tx_sample,
    input  logic              rx_slot,
    input  logic [DATA_W-1:0] rx_sample
);
    localparam int SER_IDX_W = (NUM_SER > 1) ? $clog2(NUM_SER) : 1;

    typedef struct packed {
        logic [NUM_SER-1:0][1:0] mode;
        logic                    tx_err;
        logic                    rx_err;
    } top_s;

    top_s t_d, t_q;

    logic [NSTAGE-1:0] rx_act, tx_act;
    logic              tx_full, rx_full;
    logic              tx_ev, rx_ev;
    logic [DATA_W-1:0] rx_word;
    logic [NUM_SER-1:0] tx_rdy, rx_rdy;

    logic [ADDR_W-1:0] ser_off;
    logic              ser_hit;
    logic [SER_IDX_W-1:0] ser_idx;

    assign ser_off = bus_addr - ADDR_W'(ADR_SER0);
    assign ser_hit = (bus_addr >= ADDR_W'(ADR_SER0)) && (ser_off < ADDR_W'(NUM_SER));
    assign ser_idx = ser_off[SER_IDX_W-1:0];

    logic rx_ctl_wr, tx_ctl_wr;
    assign rx_ctl_wr = bus_wr && (bus_addr == ADDR_W'(ADR_BOTH) || bus_addr == ADDR_W'(ADR_RXCTL));
    assign tx_ctl_wr = bus_wr && (bus_addr == ADDR_W'(ADR_BOTH) || bus_addr == ADDR_W'(ADR_TXCTL));

    aud_stage_chain i_rx_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (rx_ctl_wr),
        .wbits (bus_wdata[RX_LSB +: NSTAGE]),
        .act   (rx_act)
    );

    aud_stage_chain i_tx_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (tx_ctl_wr),
        .wbits (bus_wdata[TX_LSB +: NSTAGE]),
        .act   (tx_act)
    );

    aud_stage_buffer #(.DATA_W(DATA_W), .IS_TX(1'b1)) i_tx_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (!tx_act[BIT_SCLR]),
        .run       (tx_act[BIT_SM] && tx_act[BIT_FS]),
        .slot      (tx_slot),
        .host_acc  (bus_wr && bus_addr == ADDR_W'(ADR_TXBUF)),
        .host_data (bus_wdata),
        .line_data (rx_sample),
        .full      (tx_full),
        .word      (tx_sample),
        .err       (tx_ev)
    );

    aud_stage_buffer #(.DATA_W(DATA_W), .IS_TX(1'b0)) i_rx_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (!rx_act[BIT_SCLR]),
        .run       (rx_act[BIT_SM] && rx_act[BIT_FS]),
        .slot      (rx_slot),
        .host_acc  (bus_rd && bus_addr == ADDR_W'(ADR_RXBUF)),
        .host_data (bus_wdata),
        .line_data (rx_sample),
        .full      (rx_full),
        .word      (rx_word),
        .err       (rx_ev)
    );

    generate
        for (genvar n = 0; n < NUM_SER; n++) begin : g_ser
            assign tx_rdy[n] = (t_q.mode[n] == MODE_TX) && tx_act[BIT_SM] && !tx_full;
            assign rx_rdy[n] = (t_q.mode[n] == MODE_RX) && rx_full;
        end
    endgenerate

    always_comb begin
        t_d = t_q;
        for (int n = 0; n < NUM_SER; n++) begin
            if (bus_wr && ser_hit && ser_off == ADDR_W'(n))
                t_d.mode[n] = bus_wdata[1:0];
        end
        t_d.tx_err = tx_ev || (t_q.tx_err &&
                     !(bus_wr && bus_addr == ADDR_W'(ADR_TXSTAT) && bus_wdata[0]));
        t_d.rx_err = rx_ev || (t_q.rx_err &&
                     !(bus_wr && bus_addr == ADDR_W'(ADR_RXSTAT) && bus_wdata[0]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (ser_hit) begin
            bus_rdata[1:0] = t_q.mode[ser_idx];
            bus_rdata[4]   = tx_rdy[ser_idx];
            bus_rdata[5]   = rx_rdy[ser_idx];
        end else begin
            case (bus_addr)
                ADDR_W'(ADR_BOTH): begin
                    bus_rdata[RX_LSB +: NSTAGE] = rx_act;
                    bus_rdata[TX_LSB +: NSTAGE] = tx_act;
                end
                ADDR_W'(ADR_RXCTL):  bus_rdata[RX_LSB +: NSTAGE] = rx_act;
                ADDR_W'(ADR_TXCTL):  bus_rdata[TX_LSB +: NSTAGE] = tx_act;
                ADDR_W'(ADR_TXSTAT): bus_rdata[0] = t_q.tx_err;
                ADDR_W'(ADR_RXSTAT): bus_rdata[0] = t_q.rx_err;
                ADDR_W'(ADR_TXBUF):  bus_rdata = tx_sample;
                ADDR_W'(ADR_RXBUF):  bus_rdata = rx_word;
                default:             bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/aud_stage_ctrl_chk.sv
module aud_stage_ctrl_chk
    import aud_stage_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tx_slot,
    input logic              rx_slot,
    input logic [NSTAGE-1:0] rx_act,
    input logic [NSTAGE-1:0] tx_act,
    input logic              tx_full,
    input logic              rx_full,
    input logic              tx_err_q,
    input logic              rx_err_q
);
    generate
        for (genvar p = 1; p < NSTAGE; p++) begin : g_ord
            AST_ORDER_RX: assert property (@(posedge clk) disable iff (!rst_n)
                rx_act[order_bit(p)] |-> $past(rx_act[order_bit(p - 1)])); // R3
            AST_ORDER_TX: assert property (@(posedge clk) disable iff (!rst_n)
                tx_act[order_bit(p)] |-> $past(tx_act[order_bit(p - 1)])); // R3
        end
    endgenerate

    AST_STOP_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(ADR_BOTH) || bus_addr == ADDR_W'(ADR_RXCTL))
         && bus_wdata[RX_LSB +: NSTAGE] == '0) |=> (rx_act == '0)); // R4
    AST_STOP_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(ADR_BOTH) || bus_addr == ADDR_W'(ADR_TXCTL))
         && bus_wdata[TX_LSB +: NSTAGE] == '0) |=> (tx_act == '0)); // R4
    AST_HOLD_TX: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_act[BIT_SCLR] |=> !tx_full); // R6
    AST_HOLD_RX: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_act[BIT_SCLR] |=> !rx_full); // R6
    AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_err_q) |-> $past(tx_slot && tx_act[BIT_SM] && tx_act[BIT_FS] && !tx_full)); // R9
    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_err_q) |-> $past(rx_slot && rx_act[BIT_SM] && rx_act[BIT_FS] && rx_full)); // R10
    AST_TX_CLEAR_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_err_q) |-> $past(bus_wr && bus_addr == ADDR_W'(ADR_TXSTAT) && bus_wdata[0])); // R11
    AST_RX_CLEAR_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_err_q) |-> $past(bus_wr && bus_addr == ADDR_W'(ADR_RXSTAT) && bus_wdata[0])); // R11
endmodule

bind aud_stage_ctrl aud_stage_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tx_slot   (tx_slot),
    .rx_slot   (rx_slot),
    .rx_act    (rx_act),
    .tx_act    (tx_act),
    .tx_full   (tx_full),
    .rx_full   (rx_full),
    .tx_err_q  (t_q.tx_err),
    .rx_err_q  (t_q.rx_err)
);

// File: tb/test_aud_stage_ctrl.sv
module test_aud_stage_ctrl;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              tx_slot = 1'b0;
    logic [DATA_W-1:0] tx_sample;
    logic              rx_slot = 1'b0;
    logic [DATA_W-1:0] rx_sample = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    aud_stage_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SER(4)) i_aud_stage_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_slot(tx_slot), .tx_sample(tx_sample), .rx_slot(rx_slot), .rx_sample(rx_sample)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pop(input logic [4:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tx();
        tx_slot = 1'b1;
        @(negedge clk);
        tx_slot = 1'b0;
    endtask

    task automatic pulse_rx(input logic [31:0] v);
        rx_sample = v; rx_slot = 1'b1;
        @(negedge clk);
        rx_slot = 1'b0;
    endtask

    // longest in-order prefix of a requested set
    function automatic logic [4:0] settled(input logic [4:0] mask);
        logic [4:0] e = '0;
        bit go = 1;
        for (int p = 0; p < 5; p++) begin
            int b;
            b = (p == 0) ? 1 : (p == 1) ? 0 : p;
            if (go && mask[b]) e[b] = 1'b1;
            else go = 0;
        end
        return e;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(5'd0, r); check("R1 ctl", r, 32'h0);
        rd(5'd3, r); check("R1 txstat", r, 32'h0);
        rd(5'd4, r); check("R1 rxstat", r, 32'h0);
        rd(5'd8, r); check("R1 ser0", r, 32'h0);

        // R3 sweep of every requested set, both directions
        for (int dir = 0; dir < 2; dir++) begin
            for (int m = 0; m < 32; m++) begin
                logic [31:0] exp;
                wr(5'd0, 32'h0);
                idle(2);
                if (dir == 0) wr(5'd1, 32'(m));
                else          wr(5'd2, 32'(m) << 8);
                idle(12);
                rd(5'd0, r);
                exp = (dir == 0) ? {27'h0, settled(5'(m))} : {19'h0, settled(5'(m)), 8'h0};
                check("R3 prefix", r, exp);
            end
        end

        // R2 read-back latency
        wr(5'd0, 32'h0);
        wr(5'd1, 32'h2);
        rd(5'd1, r); check("R2 rx hf early", r, 32'h0);
        @(negedge clk);
        rd(5'd1, r); check("R2 rx hf on", r, 32'h2);
        wr(5'd1, 32'h3);
        rd(5'd1, r); check("R2 rx clk early", r, 32'h2);
        @(negedge clk);
        rd(5'd1, r); check("R2 rx clk on", r, 32'h3);
        wr(5'd2, 32'h200);
        rd(5'd2, r); check("R2 tx hf early", r, 32'h0);
        @(negedge clk);
        rd(5'd2, r); check("R2 tx hf on", r, 32'h200);

        // R12 stage with missing predecessor never comes up
        wr(5'd0, 32'h0);
        wr(5'd2, 32'h800);
        idle(60);
        rd(5'd2, r); check("R12 orphan stage", r, 32'h0);

        // R4 / R5 alias isolation and stop
        wr(5'd0, 32'h1F1F);
        idle(12);
        rd(5'd0, r); check("R3 all on", r, 32'h1F1F);
        wr(5'd1, 32'h1F00);
        rd(5'd0, r); check("R4 R5 rx stop via alias", r, 32'h1F00);
        rd(5'd2, r); check("R5 tx alias read", r, 32'h1F00);
        rd(5'd1, r); check("R5 rx alias read", r, 32'h0);
        wr(5'd1, 32'h1F);
        idle(12);
        wr(5'd2, 32'h001F);
        rd(5'd0, r); check("R4 R5 tx stop via alias", r, 32'h001F);
        wr(5'd0, 32'h0);
        rd(5'd0, r); check("R4 global stop", r, 32'h0);

        // transmit data path
        wr(5'd8, 32'h1);
        wr(5'd9, 32'h2);
        rd(5'd8, r); check("R7 ser0 sm off", r, 32'h1);
        wr(5'd5, 32'hA5);
        wr(5'd2, 32'h700);
        idle(10);
        wr(5'd2, 32'h1F00);
        idle(8);
        rd(5'd8, r); check("R6 write under clear dropped", r, 32'h11);
        wr(5'd5, 32'hC3);
        rd(5'd8, r); check("R7 full not ready", r, 32'h01);
        check("R9 tx_sample word", tx_sample, 32'hC3);
        pulse_tx();
        rd(5'd8, r); check("R7 ready after drain", r, 32'h11);
        rd(5'd3, r); check("R9 no underrun", r, 32'h0);
        pulse_tx();
        rd(5'd3, r); check("R9 underrun", r, 32'h1);
        wr(5'd3, 32'h0);
        rd(5'd3, r); check("R11 zero keeps", r, 32'h1);
        wr(5'd3, 32'h1);
        rd(5'd3, r); check("R11 one clears", r, 32'h0);
        tx_slot = 1'b1; bus_wr = 1'b1; bus_addr = 5'd3; bus_wdata = 32'h1;
        @(negedge clk);
        tx_slot = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd(5'd3, r); check("R11 set wins", r, 32'h1);
        wr(5'd3, 32'h1);
        rd(5'd3, r); check("R11 cleared again", r, 32'h0);

        // receive data path
        pulse_rx(32'h77);
        rd(5'd9, r); check("R6 rx capture while off", r, 32'h2);
        rd(5'd4, r); check("R6 no overrun while off", r, 32'h0);
        wr(5'd1, 32'h1F);
        idle(12);
        pulse_rx(32'h1234);
        rd(5'd9, r); check("R8 rx ready", r, 32'h22);
        rd(5'd8, r); check("R8 tx-mode no rx flag", r, 32'h11);
        pop(5'd6, r); check("R8 rx word", r, 32'h1234);
        rd(5'd9, r); check("R8 ready cleared", r, 32'h2);
        pulse_rx(32'h55);
        pulse_rx(32'h66);
        rd(5'd4, r); check("R10 overrun", r, 32'h1);
        pop(5'd6, r); check("R10 first kept", r, 32'h55);
        wr(5'd4, 32'h1);
        rd(5'd4, r); check("R11 rx clear", r, 32'h0);
        rd(5'd10, r); check("R7 idle serializer", r, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule